// File: doc/BRIEF.md
# Zero-Padded Spectrum Frame Builder

This block prepares the frequency-domain input of a 256-point inverse transform that runs at twice the subcarrier sample rate. It accepts 128 complex QPSK subcarrier values per symbol, one per accepted beat. Each component is 3-bit two's complement. It emits a 256-bin frame in which the positive-frequency half sits at the bottom of the frame and the negative-frequency half sits at the top. The 128 bins in the middle are zero. Placing the zeros there leaves a wide empty band around the image of the oversampled signal, so the analog reconstruction filter can be of low order.

The frame leaves the block as four parallel lanes per beat, which suits a four-way parallel transform core. Over 64 accepted output beats, lane k carries the bins whose index is congruent to k modulo 4. The block holds two symbol buffers. It can collect one symbol while it emits the previous one, so a steady input stream is not stalled.

Both streaming edges use valid/ready. `in_ready` depends only on internal state and never on `in_valid`. An input beat is taken on a clock edge where both `in_valid` and `in_ready` are high. An output beat is consumed on an edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, every output holds still. When both buffers hold unread symbols, `in_ready` drops until the oldest frame has been fully consumed.

Top module: `zp_ifft_mapper`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The input sample with index n (0 to 63, counted from the start of the symbol) is placed in bin n. These are the non-negative logical frequencies 0 to 63.
- R3: The input sample with index n (64 to 127) is placed in bin n+128, that is, bins 192 to 255. These carry the logical frequencies -64 to -1.
- R4: Bins 64 to 191 always carry zero in both components.
- R5: A frame takes 64 output beats. On beat c, lane k carries bin 4c+k. Lane k occupies bits [3k+2:3k] of `out_re` and of `out_im`.
- R6: `out_sof` is high on the first beat of each frame and low on its other 63 beats.
- R7: When no frame is pending, `out_valid` goes high in the cycle after the edge that accepts the 128th sample of a symbol, and not before.
- R8: While one completed frame waits or is being emitted, `in_ready` stays high for the next symbol. When two completed frames are unread, `in_ready` is 0, and it returns to 1 once a frame has been fully consumed.
- R9: Cycles with `in_valid` low leave the write position unchanged, and the partly filled buffer keeps its contents.
- R10: An accepted beat with `in_sos` high is stored as sample index 0 of a new symbol, and any partly collected symbol is discarded.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sof`, `out_re` and `out_im` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_sos | input | 1 | Sample is index 0 of a new symbol |
| in_re | input | 3 | Real component, signed |
| in_im | input | 3 | Imaginary component, signed |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_sof | output | 1 | First beat of a frame |
| out_re | output | 12 | Real parts of four lanes, lane k at [3k+2:3k] |
| out_im | output | 12 | Imaginary parts of four lanes, lane k at [3k+2:3k] |

## Verification
The only register between an input sample and its frame is the buffer-full flag. A completed symbol therefore shows `out_valid` and `out_sof` in the first cycle after the edge that takes its 128th sample, and the bench looks for them at the falling edge that follows. Output data is a combinational read of stored state, so each beat is compared at the falling edge before the rising edge that consumes it. The bench expects beat c of frame f to contain bins 4c to 4c+3, computed from an arithmetic formula for frame f's samples. It advances its own beat and frame counts only on edges where it saw both valid and ready high. The same edge-by-edge accounting of accepted inputs covers the stall when both buffers are full and the held outputs under back-pressure.

// File: rtl/zp_pkg.sv
package zp_pkg;
  parameter int ZP_SUBCARRIERS = 128;
  parameter int ZP_LANES       = 4;
  parameter int ZP_WIDTH       = 3;

  typedef enum logic [1:0] {
    SEG_LOW  = 2'd0,
    SEG_GAP  = 2'd1,
    SEG_HIGH = 2'd2
  } seg_e;
endpackage

// File: rtl/zp_wr_ctrl.sv
module zp_wr_ctrl #(
  parameter int NUM_SC = 128,
  localparam int IW = $clog2(NUM_SC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sos,
  input  logic [1:0]    buf_full,
  output logic          in_ready,
  output logic          wr_en,
  output logic          wr_buf,
  output logic [IW-1:0] wr_idx,
  output logic          fill_done
);
  logic          sel_q;
  logic [IW-1:0] pos_q;

  assign in_ready  = ~buf_full[sel_q];
  assign wr_en     = in_valid & in_ready;
  assign wr_buf    = sel_q;
  assign wr_idx    = in_sos ? '0 : pos_q;
  assign fill_done = wr_en & (wr_idx == IW'(NUM_SC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      pos_q <= '0;
    end else if (wr_en) begin
      if (fill_done) begin
        pos_q <= '0;
        sel_q <= ~sel_q;
      end else begin
        pos_q <= wr_idx + IW'(1);
      end
    end
  end
endmodule

// File: rtl/zp_store.sv
module zp_store #(
  parameter int NUM_SC = 128,
  parameter int LANES  = 4,
  parameter int DW     = 3,
  localparam int IW    = $clog2(NUM_SC),
  localparam int ROWS  = NUM_SC / LANES,
  localparam int RW    = $clog2(ROWS),
  localparam int LW    = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic                  wr_buf,
  input  logic [IW-1:0]         wr_idx,
  input  logic [DW-1:0]         wr_re,
  input  logic [DW-1:0]         wr_im,
  input  logic                  rd_buf,
  input  logic [RW-1:0]         rd_row,
  output logic [LANES*DW-1:0]   rd_re,
  output logic [LANES*DW-1:0]   rd_im
);
  logic [RW-1:0] w_row;
  logic [LW-1:0] w_lane;

  assign w_row  = wr_idx[IW-1:LW];
  assign w_lane = wr_idx[LW-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DW-1:0] mem_re [2*ROWS];
    logic [DW-1:0] mem_im [2*ROWS];

    always_ff @(posedge clk) begin
      if (wr_en && (w_lane == LW'(k))) begin
        mem_re[{wr_buf, w_row}] <= wr_re;
        mem_im[{wr_buf, w_row}] <= wr_im;
      end
    end

    assign rd_re[k*DW +: DW] = mem_re[{rd_buf, rd_row}];
    assign rd_im[k*DW +: DW] = mem_im[{rd_buf, rd_row}];
  end
endmodule

// File: rtl/zp_rd_ctrl.sv
module zp_rd_ctrl
  import zp_pkg::*;
#(
  parameter int NUM_SC = 128,
  parameter int LANES  = 4,
  localparam int BEATS = 2 * NUM_SC / LANES,
  localparam int ROWS  = NUM_SC / LANES,
  localparam int HALF  = ROWS / 2,
  localparam int BW    = $clog2(BEATS),
  localparam int RW    = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    buf_full,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_sof,
  output logic          rd_buf,
  output logic [RW-1:0] rd_row,
  output logic          gap,
  output logic          drain_done
);
  logic          sel_q;
  logic [BW-1:0] beat_q;
  logic [BW-1:0] row_full;
  seg_e          seg;

  always_comb begin
    if (beat_q < BW'(HALF))              seg = SEG_LOW;
    else if (beat_q >= BW'(BEATS - HALF)) seg = SEG_HIGH;
    else                                  seg = SEG_GAP;
  end

  assign row_full   = (seg == SEG_HIGH) ? beat_q - BW'(BEATS - ROWS) : beat_q;
  assign rd_row     = row_full[RW-1:0];
  assign gap        = (seg == SEG_GAP);
  assign rd_buf     = sel_q;
  assign out_valid  = buf_full[sel_q];
  assign out_sof    = out_valid & (beat_q == '0);
  assign drain_done = out_valid & out_ready & (beat_q == BW'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      beat_q <= '0;
    end else if (out_valid && out_ready) begin
      if (drain_done) begin
        beat_q <= '0;
        sel_q  <= ~sel_q;
      end else begin
        beat_q <= beat_q + BW'(1);
      end
    end
  end
endmodule

// File: rtl/zp_ifft_mapper.sv
module zp_ifft_mapper
  import zp_pkg::*;
#(
  parameter int NUM_SC = ZP_SUBCARRIERS,
  parameter int LANES  = ZP_LANES,
  parameter int DW     = ZP_WIDTH,
  localparam int IW    = $clog2(NUM_SC),
  localparam int ROWS  = NUM_SC / LANES,
  localparam int RW    = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sos,
  input  logic [DW-1:0]       in_re,
  input  logic [DW-1:0]       in_im,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_sof,
  output logic [LANES*DW-1:0] out_re,
  output logic [LANES*DW-1:0] out_im
);
  logic [1:0]          full_q;
  logic                wr_en, wr_buf, fill_done;
  logic [IW-1:0]       wr_idx;
  logic                rd_buf, gap, drain_done;
  logic [RW-1:0]       rd_row;
  logic [LANES*DW-1:0] st_re, st_im;

  zp_wr_ctrl #(.NUM_SC(NUM_SC)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
    .buf_full(full_q), .in_ready(in_ready), .wr_en(wr_en),
    .wr_buf(wr_buf), .wr_idx(wr_idx), .fill_done(fill_done)
  );

  zp_store #(.NUM_SC(NUM_SC), .LANES(LANES), .DW(DW)) u_st (
    .clk(clk), .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx),
    .wr_re(in_re), .wr_im(in_im), .rd_buf(rd_buf), .rd_row(rd_row),
    .rd_re(st_re), .rd_im(st_im)
  );

  zp_rd_ctrl #(.NUM_SC(NUM_SC), .LANES(LANES)) u_rd (
    .clk(clk), .rst_n(rst_n), .buf_full(full_q), .out_ready(out_ready),
    .out_valid(out_valid), .out_sof(out_sof), .rd_buf(rd_buf),
    .rd_row(rd_row), .gap(gap), .drain_done(drain_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 2'b00;
    end else begin
      if (fill_done)  full_q[wr_buf] <= 1'b1;
      if (drain_done) full_q[rd_buf] <= 1'b0;
    end
  end

  assign out_re = gap ? '0 : st_re;
  assign out_im = gap ? '0 : st_im;
endmodule

// File: rtl/zp_mapper_chk.sv
module zp_mapper_chk #(
  parameter int NUM_SC = 128,
  parameter int LANES  = 4,
  parameter int DW     = 3,
  localparam int BEATS = 2 * NUM_SC / LANES,
  localparam int HALF  = NUM_SC / LANES / 2,
  localparam int BW    = $clog2(BEATS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_sof,
  input logic [LANES*DW-1:0] out_re,
  input logic [LANES*DW-1:0] out_im
);
  logic [BW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (out_valid && out_ready) seen_q <= seen_q + BW'(1);
  end

  a_r11_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sof) &&
                                   $stable(out_re) && $stable(out_im)));

  a_r6_sof_on_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == (seen_q == '0)));

  a_r4_middle_bins_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q >= BW'(HALF) && seen_q < BW'(BEATS - HALF))
      |-> (out_re == '0 && out_im == '0));

  a_r8_stall_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  a_r6_sof_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
endmodule

bind zp_ifft_mapper zp_mapper_chk #(.NUM_SC(NUM_SC), .LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sof(out_sof), .out_re(out_re), .out_im(out_im)
);

// File: tb/sim_zp_ifft_mapper.sv
module sim_zp_ifft_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sos = 1'b0, out_ready = 1'b0;
  logic [2:0]  in_re = '0, in_im = '0;
  logic        in_ready, out_valid, out_sof;
  logic [11:0] out_re, out_im;

  int total = 0, bad = 0;
  int wr_f = 0, wr_n = 0, rd_f = 0, rd_beat = 0, n_frames = 6;
  int junk_n = 0, junk_left = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  zp_ifft_mapper u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sos(in_sos), .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_ready(out_ready), .out_sof(out_sof), .out_re(out_re), .out_im(out_im)
  );

  function automatic logic [2:0] vre(int f, int n);
    return 3'((n * 3 + f * 5 + 1) & 7);
  endfunction
  function automatic logic [2:0] vim(int f, int n);
    return 3'((n * 7 + f * 3 + 2) & 7);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6: compare one beat against bins 4c..4c+3 of frame rd_f
  task automatic check_beat();
    logic [11:0] er, ei;
    string tag;
    for (int k = 0; k < 4; k++) begin
      int b = 4 * rd_beat + k;
      if (b < 64) begin
        er[3*k +: 3] = vre(rd_f, b); ei[3*k +: 3] = vim(rd_f, b);
      end else if (b >= 192) begin
        er[3*k +: 3] = vre(rd_f, b - 128); ei[3*k +: 3] = vim(rd_f, b - 128);
      end else begin
        er[3*k +: 3] = '0; ei[3*k +: 3] = '0;
      end
    end
    tag = (rd_beat < 16) ? "R2/R5 re" : (rd_beat >= 48) ? "R3/R5 re" : "R4 re";
    chk(tag, 32'(out_re), 32'(er));
    tag = (rd_beat < 16) ? "R2/R5 im" : (rd_beat >= 48) ? "R3/R5 im" : "R4 im";
    chk(tag, 32'(out_im), 32'(ei));
    chk("R6 sof", 32'(out_sof), 32'(rd_beat == 0));
  endtask

  task automatic tick(input bit iv, input bit ordy);
    bit acc_in, acc_out;
    if (junk_left > 0) begin
      in_valid = iv;
      in_sos   = (junk_n == 0);
      in_re    = vre(99, junk_n);
      in_im    = vim(99, junk_n);
    end else begin
      in_valid = iv && (wr_f < n_frames);
      in_sos   = (wr_n == 0);
      in_re    = vre(wr_f, wr_n);
      in_im    = vim(wr_f, wr_n);
    end
    out_ready = ordy;
    #1;
    acc_out = out_valid && ordy;
    acc_in  = in_valid && in_ready;
    if (acc_out) check_beat();
    @(posedge clk);
    if (acc_out) begin
      rd_beat++;
      if (rd_beat == 64) begin rd_beat = 0; rd_f++; end
    end
    if (acc_in) begin
      if (junk_left > 0) begin
        junk_n++; junk_left--;
      end else begin
        wr_n++;
        if (wr_n == 128) begin wr_n = 0; wr_f++; end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] hold_re, hold_im;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: frame 0 with consumer stalled
    for (int i = 0; i < 127; i++) tick(1, 0);
    chk("R7 early", 32'(out_valid), 0);
    tick(1, 0);
    chk("R7 valid", 32'(out_valid), 1);
    chk("R6 first sof", 32'(out_sof), 1);

    // R8: second buffer fills while frame 0 waits
    chk("R8 ready one pending", 32'(in_ready), 1);
    for (int i = 0; i < 128; i++) tick(1, 0);
    chk("R8 both full", 32'(in_ready), 0);
    hold_re = out_re; hold_im = out_im;
    for (int i = 0; i < 3; i++) tick(1, 0);
    chk("R8 still stalled", 32'(in_ready), 0);
    chk("R11 re held", 32'(out_re), 32'(hold_re));
    chk("R11 im held", 32'(out_im), 32'(hold_im));
    chk("R11 valid held", 32'(out_valid), 1);

    // R9 R11: gaps on both sides while streaming frames 0..5
    for (int cyc = 0; cyc < 20000 && rd_f < 6; cyc++)
      tick((cyc % 3) != 0, (cyc % 5) != 2);
    chk("R9 frames drained", 32'(rd_f), 6);
    chk("R8 released", 32'(in_ready), 1);
    chk("R1 idle valid", 32'(out_valid), 0);

    // R10: partial symbol then restart with start-of-symbol
    n_frames = 7;
    junk_left = 50;
    for (int cyc = 0; cyc < 200 && junk_left > 0; cyc++) tick(1, 1);
    chk("R10 no early frame", 32'(out_valid), 0);
    for (int cyc = 0; cyc < 2000 && rd_f < 7; cyc++) tick(1, 1);
    chk("R10 restarted frame out", 32'(rd_f), 7);
    chk("R10 nothing left", 32'(out_valid), 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule